// File: doc/BRIEF.md
# Processor-Side Interrupt Priority Gate

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers one candidate interrupt (an ID and an 8-bit priority). The block decides whether that candidate is strong enough to raise the processor's interrupt request line. To decide, it checks the candidate against a priority mask and against the priority of the interrupts the processor is already servicing. Lower numbers mean higher priority.

An acknowledge pulse takes the current candidate. The block returns its ID, or the spurious ID 1023 if the candidate is not good enough. The taken candidate's priority is pushed onto a running-priority stack. A completion write pops that stack, which lowers the running priority. Deactivation goes out to the distributor as a pulse. It is issued either together with the completion write or later by a separate deactivate write, depending on a mode bit. Preemption compares only the group part of each priority. A 3-bit split point chooses how many low-order bits are left out of that comparison.

Top module: `irq_cpu_gate`

## Requirements
- R1: A candidate is signalled only if its quantized priority is numerically below the quantized mask `pmask`, compared on all implemented bits. A mask of 0 masks every candidate.
- R2: Only the top `PRIO_BITS` (default 5) priority bits are implemented, and lower bits are treated as zero. So a mask of 0xFF acts as 0xF8, and a candidate whose priority is 0xF8 to 0xFF is never signalled.
- R3: With no active entry, `run_prio` reads 0xFF, and any unmasked, valid candidate is signalled whatever its group value.
- R4: With at least one active entry, a candidate preempts only if (quantized priority AND G) is strictly less than (`run_prio` AND G). G keeps bits [7:`bpoint`+1]; with `bpoint`=7, G is 0 and nothing preempts.
- R5: An acknowledge while the candidate is sufficient returns `cand_id` on `ack_id` in the next cycle. From then on, `run_prio` equals the candidate's quantized priority.
- R6: An acknowledge while no candidate is sufficient returns 1023 on `ack_id` and leaves `run_prio` unchanged.
- R7: `irq` is registered: it shows the sufficiency decision of the previous clock edge. It therefore falls one cycle after an acknowledge if the remaining candidate no longer preempts.
- R8: A completion write with `eoi_id` ≤ 1019 while an entry is active pops the most recent entry. `run_prio` then becomes the next older entry, or 0xFF. A completion write with an ID above 1019, or one made with nothing active, changes nothing.
- R9: With `eoi_mode`=0, a valid completion write produces a one-cycle `deact_vld` pulse with `deact_id` = `eoi_id`; deactivate writes are ignored.
- R10: With `eoi_mode`=1, a completion write produces no deactivation; a deactivate write produces a one-cycle `deact_vld` pulse with `deact_id` = `dir_id`.
- R11: When `DEPTH` (default 8) entries are active, no candidate is signalled and an acknowledge returns 1023.
- R12: An acknowledge and a valid completion write in the same cycle replace the most recent entry with the candidate. `run_prio` becomes the candidate's quantized priority and the depth stays the same.
- R13: With `if_en` low, `irq` is low and an acknowledge returns 1023.
- R14: After reset: `irq`=0, `run_prio`=0xFF, `ack_id`=1023, `deact_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Interface enable for signalling |
| pmask | input | 8 | Priority mask value |
| bpoint | input | 3 | Group/subpriority split point |
| eoi_mode | input | 1 | 0: completion also deactivates; 1: separate deactivate |
| cand_valid | input | 1 | Distributor candidate present |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority |
| ack | input | 1 | Acknowledge read pulse |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| eoi_wr | input | 1 | Completion write pulse |
| eoi_id | input | 10 | ID carried by completion write |
| dir_wr | input | 1 | Deactivate write pulse |
| dir_id | input | 10 | ID carried by deactivate write |
| irq | output | 1 | Interrupt request to processor |
| run_prio | output | 8 | Current running priority |
| deact_vld | output | 1 | Deactivate pulse toward distributor |
| deact_id | output | 10 | ID to deactivate |

## Verification
An acknowledge and a completion write can arrive in the same cycle, and the stack must then pop and push at once. The directed part forces this case: it acknowledges a low-priority interrupt, offers a higher one, and then pulses both strobes together. The bench checks that `ack_id` shows the new ID, that `run_prio` equals the new priority, and that a single further completion returns the running priority to idle. The random phase sets the acknowledge and completion strobes independently, so the same collision recurs, and each cycle a bench-side stack model judges it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID   = 10'd1023;
  localparam logic [ID_W-1:0] LAST_VALID_ID = 10'd1019;
  localparam logic [7:0]      IDLE_PRIO     = 8'hFF;

  // keep the top 'bits' bits of a priority value
  function automatic logic [7:0] impl_mask(input int unsigned bits);
    return 8'hFF << (8 - bits);
  endfunction

  // bits [7:bp+1] form the group part used for preemption
  function automatic logic [7:0] group_mask(input logic [2:0] bp);
    return 8'hFF << ({1'b0, bp} + 4'd1);
  endfunction
endpackage

// File: rtl/irq_active_stack.sv
module irq_active_stack
  import irq_prio_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       pop,
  input  logic [7:0] push_prio,
  output logic [7:0] top_prio,
  output logic       empty,
  output logic       full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SP_W  = $clog2(DEPTH + 1);

  logic [7:0]      mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [IDX_W-1:0] top_idx, wr_idx;
  logic do_pop, do_push;

  assign empty   = (sp == '0);
  assign full    = (sp == SP_W'(DEPTH));
  assign top_idx = IDX_W'(sp - SP_W'(1));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign wr_idx  = do_pop ? top_idx : IDX_W'(sp);

  // storage without reset so it may map to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_prio;
  end

  always_ff @(posedge clk) begin
    if (rst)                      sp <= '0;
    else if (do_push && !do_pop)  sp <= sp + SP_W'(1);
    else if (do_pop && !do_push)  sp <= sp - SP_W'(1);
  end

  assign top_prio = empty ? IDLE_PRIO : mem[top_idx];

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sp <= SP_W'(DEPTH));
endmodule

// File: rtl/irq_preempt_cmp.sv
module irq_preempt_cmp
  import irq_prio_pkg::*;
#(
  parameter int PRIO_BITS = 5
) (
  input  logic       if_en,
  input  logic       cand_valid,
  input  logic [7:0] cand_prio,
  input  logic [7:0] pmask,
  input  logic [2:0] bpoint,
  input  logic [7:0] run_prio,
  input  logic       stk_empty,
  input  logic       stk_full,
  output logic [7:0] cand_q,
  output logic       sufficient
);
  localparam logic [7:0] IMPL = impl_mask(PRIO_BITS);

  logic [7:0] mask_q, gmask;
  logic unmasked, preempts;

  assign cand_q   = cand_prio & IMPL;
  assign mask_q   = pmask & IMPL;
  assign gmask    = group_mask(bpoint);
  assign unmasked = cand_q < mask_q;
  assign preempts = stk_empty || ((cand_q & gmask) < (run_prio & gmask));
  assign sufficient = if_en && cand_valid && unmasked && preempts && !stk_full;
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate
  import irq_prio_pkg::*;
#(
  parameter int PRIO_BITS = 5,
  parameter int DEPTH     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            if_en,
  input  logic [7:0]      pmask,
  input  logic [2:0]      bpoint,
  input  logic            eoi_mode,
  input  logic            cand_valid,
  input  logic [ID_W-1:0] cand_id,
  input  logic [7:0]      cand_prio,
  input  logic            ack,
  output logic [ID_W-1:0] ack_id,
  input  logic            eoi_wr,
  input  logic [ID_W-1:0] eoi_id,
  input  logic            dir_wr,
  input  logic [ID_W-1:0] dir_id,
  output logic            irq,
  output logic [7:0]      run_prio,
  output logic            deact_vld,
  output logic [ID_W-1:0] deact_id
);
  logic [7:0] cand_q;
  logic suff, stk_empty, stk_full, eoi_ok, take;

  assign eoi_ok = eoi_wr && (eoi_id <= LAST_VALID_ID) && !stk_empty;
  assign take   = ack && suff;

  irq_preempt_cmp #(.PRIO_BITS(PRIO_BITS)) u_cmp (
    .if_en(if_en), .cand_valid(cand_valid), .cand_prio(cand_prio),
    .pmask(pmask), .bpoint(bpoint), .run_prio(run_prio),
    .stk_empty(stk_empty), .stk_full(stk_full),
    .cand_q(cand_q), .sufficient(suff)
  );

  irq_active_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(take), .pop(eoi_ok),
    .push_prio(cand_q), .top_prio(run_prio),
    .empty(stk_empty), .full(stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      ack_id    <= SPURIOUS_ID;
      deact_vld <= 1'b0;
      deact_id  <= '0;
    end else begin
      irq <= suff;
      if (ack) ack_id <= suff ? cand_id : SPURIOUS_ID;
      deact_vld <= (eoi_ok && !eoi_mode) || (dir_wr && eoi_mode);
      deact_id  <= eoi_mode ? dir_id : eoi_id;
    end
  end

  // R13
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(if_en));
  // R6
  spur_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !suff && !eoi_ok) |=> run_prio == $past(run_prio));
  // R5
  ack_sets_run_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && suff) |=> run_prio == $past(cand_q));
  // R9
  no_deact_mode0_chk: assert property (@(posedge clk) disable iff (rst)
    (!eoi_mode && !eoi_wr) |=> !deact_vld);
  // R8
  bad_eoi_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && eoi_id > LAST_VALID_ID && !ack) |=> run_prio == $past(run_prio));
endmodule

// File: tb/test_irq_cpu_gate.sv
module test_irq_cpu_gate;
  logic clk = 1'b0, rst = 1'b1;
  logic if_en = 0, eoi_mode = 0, cand_valid = 0, ack = 0, eoi_wr = 0, dir_wr = 0;
  logic [7:0] pmask = 0, cand_prio = 0;
  logic [2:0] bpoint = 0;
  logic [9:0] cand_id = 0, eoi_id = 0, dir_id = 0;
  logic [9:0] ack_id, deact_id;
  logic irq, deact_vld;
  logic [7:0] run_prio;

  int total = 0, bad = 0;
  logic [7:0] m_stk [8];
  int m_sp = 0;
  logic [9:0] m_ack = 10'd1023;

  always #4 clk = ~clk;

  irq_cpu_gate i_irq_cpu_gate (
    .clk(clk), .rst(rst), .if_en(if_en), .pmask(pmask), .bpoint(bpoint),
    .eoi_mode(eoi_mode), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .ack(ack), .ack_id(ack_id), .eoi_wr(eoi_wr),
    .eoi_id(eoi_id), .dir_wr(dir_wr), .dir_id(dir_id), .irq(irq),
    .run_prio(run_prio), .deact_vld(deact_vld), .deact_id(deact_id)
  );

  function automatic logic [7:0] q(input logic [7:0] p);
    return p & 8'hF8;
  endfunction
  function automatic logic [7:0] gm(input logic [2:0] b);
    return 8'hFF << (int'(b) + 1);
  endfunction
  function automatic logic [7:0] m_run();
    return (m_sp == 0) ? 8'hFF : m_stk[m_sp-1];
  endfunction
  function automatic logic m_suff();
    if (!(if_en && cand_valid)) return 1'b0;
    if (!(q(cand_prio) < q(pmask))) return 1'b0;
    if (m_sp >= 8) return 1'b0;
    if (m_sp == 0) return 1'b1;
    return (q(cand_prio) & gm(bpoint)) < (m_run() & gm(bpoint));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock with model update and output comparison
  task automatic cyc();
    logic s, eok, dv;
    logic [9:0] did;
    s   = m_suff();
    eok = eoi_wr && (eoi_id <= 10'd1019) && (m_sp > 0);
    dv  = (eok && !eoi_mode) || (dir_wr && eoi_mode);
    did = eoi_mode ? dir_id : eoi_id;
    if (ack) m_ack = s ? cand_id : 10'd1023;
    @(posedge clk);
    if (ack && s && eok) m_stk[m_sp-1] = q(cand_prio);
    else if (ack && s) begin m_stk[m_sp] = q(cand_prio); m_sp++; end
    else if (eok) m_sp--;
    @(negedge clk);
    chk(irq == s, "R7 irq", irq, s);
    chk(run_prio == m_run(), "R8 run_prio", run_prio, m_run());
    chk(ack_id == m_ack, "R5 ack_id", ack_id, m_ack);
    chk(deact_vld == dv, "R9 deact_vld", deact_vld, dv);
    if (dv) chk(deact_id == did, "R10 deact_id", deact_id, did);
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(); ack = 0;
  endtask
  task automatic pulse_eoi(input logic [9:0] id);
    eoi_wr = 1; eoi_id = id; cyc(); eoi_wr = 0;
  endtask
  task automatic pulse_dir(input logic [9:0] id);
    dir_wr = 1; dir_id = id; cyc(); dir_wr = 0;
  endtask
  task automatic offer(input logic [7:0] p, input logic [9:0] id);
    cand_valid = 1; cand_prio = p; cand_id = id; cyc(); cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R14 reset state
    chk(irq == 0, "R14 irq", irq, 0);
    chk(run_prio == 8'hFF, "R14 run_prio", run_prio, 8'hFF);
    chk(ack_id == 10'd1023, "R14 ack_id", ack_id, 1023);
    chk(deact_vld == 0, "R14 deact_vld", deact_vld, 0);

    if_en = 1; pmask = 0;
    offer(8'h10, 10'd40);
    chk(irq == 0, "R1 mask zero", irq, 0);
    pmask = 8'hFF;
    offer(8'hFC, 10'd40);
    chk(irq == 0, "R2 lowest level masked", irq, 0);
    offer(8'hF7, 10'd40);
    chk(irq == 1, "R3 idle signals", irq, 1);
    chk(run_prio == 8'hFF, "R3 idle run", run_prio, 8'hFF);
    pulse_ack();
    chk(ack_id == 10'd40, "R5 ack id", ack_id, 40);
    chk(run_prio == 8'hF0, "R5 run", run_prio, 8'hF0);
    cyc();
    chk(irq == 0, "R7 drop after ack", irq, 0);
    offer(8'hF0, 10'd41);
    chk(irq == 0, "R4 same group", irq, 0);
    offer(8'hE8, 10'd41);
    chk(irq == 1, "R4 higher group", irq, 1);
    bpoint = 3'd4; cyc(); cyc();
    chk(irq == 0, "R4 coarse group", irq, 0);
    pulse_ack();
    chk(ack_id == 10'd1023, "R6 spurious", ack_id, 1023);
    chk(run_prio == 8'hF0, "R6 run kept", run_prio, 8'hF0);
    bpoint = 3'd0; cyc();
    pulse_ack();
    chk(run_prio == 8'hE8, "R5 nested run", run_prio, 8'hE8);
    pulse_eoi(10'd1020);
    chk(run_prio == 8'hE8 && !deact_vld, "R8 id above 1019", run_prio, 8'hE8);
    pulse_eoi(10'd41);
    chk(run_prio == 8'hF0, "R8 pop", run_prio, 8'hF0);
    chk(deact_vld && deact_id == 10'd41, "R9 deact with eoi", deact_id, 41);
    pulse_dir(10'd7);
    chk(!deact_vld, "R9 dir ignored", deact_vld, 0);
    eoi_mode = 1;
    pulse_eoi(10'd40);
    chk(run_prio == 8'hFF && !deact_vld, "R10 drop only", run_prio, 8'hFF);
    pulse_dir(10'd40);
    chk(deact_vld && deact_id == 10'd40, "R10 dir deact", deact_id, 40);

    // R12 ack and completion in the same cycle
    offer(8'h80, 10'd50); pulse_ack();
    offer(8'h40, 10'd51);
    ack = 1; eoi_wr = 1; eoi_id = 10'd50; cyc(); ack = 0; eoi_wr = 0;
    chk(ack_id == 10'd51, "R12 ack id", ack_id, 51);
    chk(run_prio == 8'h40, "R12 run", run_prio, 8'h40);
    pulse_eoi(10'd51);
    chk(run_prio == 8'hFF, "R12 single pop", run_prio, 8'hFF);

    // R11 fill the stack
    for (int i = 0; i < 8; i++) begin
      offer(8'h78 - 8'(8 * i), 10'(60 + i)); pulse_ack();
    end
    offer(8'h00, 10'd99);
    chk(irq == 0, "R11 full no irq", irq, 0);
    pulse_ack();
    chk(ack_id == 10'd1023, "R11 full spurious", ack_id, 1023);
    for (int i = 0; i < 8; i++) pulse_eoi(10'(67 - i));
    chk(run_prio == 8'hFF, "R8 all popped", run_prio, 8'hFF);

    if_en = 0; offer(8'h00, 10'd5);
    chk(irq == 0, "R13 disabled", irq, 0);
    pulse_ack();
    chk(ack_id == 10'd1023, "R13 spurious", ack_id, 1023);
    if_en = 1;

    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      cand_valid = ($urandom % 8) != 0;
      cand_prio  = 8'($urandom);
      cand_id    = 10'($urandom % 1020);
      pmask      = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
      if (n % 50 == 0) bpoint = 3'($urandom);
      if (n % 300 == 0) eoi_mode = 1'($urandom);
      if_en  = ($urandom % 20) != 0;
      ack    = ($urandom % 10) < 3;
      eoi_wr = ($urandom % 10) < 2;
      eoi_id = ($urandom % 8 == 0) ? 10'(1020 + $urandom % 4) : 10'($urandom % 1020);
      dir_wr = ($urandom % 10) == 0;
      dir_id = 10'($urandom % 1020);
      cyc();
    end
    ack = 0; eoi_wr = 0; dir_wr = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule